// File: doc/BRIEF.md
# Banked and Indirect Register-File Address Generator

This unit produces the 8-bit address for a 256-entry register file. The file holds the general-purpose storage and the special registers, including the low byte of the program counter. An instruction supplies only a 7-bit file field. For a direct access, a bank bit taken from the status register becomes the most significant address bit. Bank 0 covers 0x00 to 0x7F and bank 1 covers 0x80 to 0xFF.

One slot in each bank, field value 0x00, is a pseudo-register with no storage behind it. An access that names this slot is redirected: the full 8-bit value of a pointer register becomes the address, and the bank bit plays no part. If the pointer itself names the pseudo-register (pointer 0x00 or 0x80), the unit raises a self-reference flag. The file then returns 0x00 for that access.

The address and both flags are registered, so each result appears one clock after its inputs. The register file, the ALU and instruction decode are outside this unit.

Top module: `rfa_addresser`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the outputs become `eff_addr_o` = 0x00, `via_ptr_o` = 0 and `self_ref_o` = 0.
- R2: When `file_field_i` is not 0x00, the output one clock later is `eff_addr_o` = {`bank_i`, `file_field_i`}, with `bank_i` as bit 7 and the field as bits 6..0, and `via_ptr_o` = 0.
- R3: For a direct access, `bank_i` = 0 gives an address in 0x01..0x7F and `bank_i` = 1 gives an address in 0x81..0xFF.
- R4: When `file_field_i` is 0x00, the output one clock later is `eff_addr_o` = `ptr_i` (all 8 bits) and `via_ptr_o` = 1.
- R5: During an indirect access, `bank_i` has no effect on any output.
- R6: During an indirect access, `self_ref_o` is 1 exactly when bits 6..0 of `ptr_i` are zero, that is for pointer 0x00 or 0x80. `eff_addr_o` still equals the pointer value.
- R7: `self_ref_o` is never 1 while `via_ptr_o` is 0.
- R8: During a direct access, `ptr_i` has no effect on any output. A pointer of 0x00 or 0x80 does not raise `self_ref_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| file_field_i | input | 7 | File field from the instruction; 0x00 names the indirect pseudo-register |
| bank_i | input | 1 | Bank-select bit taken from the status register |
| ptr_i | input | 8 | Pointer register value used for indirect accesses |
| eff_addr_o | output | 8 | Registered effective register-file address |
| via_ptr_o | output | 1 | Registered flag: the address came from the pointer |
| self_ref_o | output | 1 | Registered flag: the pointer names the pseudo-register, so the read returns 0x00 |

## Verification
The hardest case to reach is the self-reference corner. It needs a zero file field together with a pointer whose low seven bits are zero, and it must be tried with both bank values and both pointer MSBs. The stimulus drives this combination on purpose in all four variants. It also drives the opposite case, a direct access carrying pointer 0x00 or 0x80, to show that the flag stays low. A random-walk phase then biases the field and the pointer toward zero so the corner also occurs next to ordinary accesses and around a mid-run reset.

// File: rtl/rfa_pkg.sv
// Package: shared widths, slot position and result record for the
// register-file address generator. Assumes a single bank bit that sits
// above a FIELD_W-bit direct field.
package rfa_pkg;
    localparam int FIELD_W  = 7;
    localparam int ADDR_W   = FIELD_W + 1;
    localparam int IND_SLOT = 0;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              via_ptr;
        logic              self_ref;
    } rfa_res_t;
endpackage

// File: rtl/rfa_slot_match.sv
// Module: rfa_slot_match
// Flags when a W-bit in-bank offset equals the pseudo-register slot.
// Assumes the slot sits at the same offset in every bank.
module rfa_slot_match #(
    parameter int W    = 7,
    parameter int SLOT = 0
) (
    input  logic [W-1:0] offset_i,
    output logic         hit_o
);
    localparam logic [W-1:0] SLOT_V = W'(SLOT);

    // Purpose: compare the offset with the pseudo-register position.
    always_comb begin
        hit_o = (offset_i == SLOT_V);
    end
endmodule

// File: rtl/rfa_route.sv
// Module: rfa_route
// Picks the direct (bank-extended) or indirect (pointer) address and
// forms the two flags. Purely combinational; the caller registers it.
module rfa_route #(
    parameter int FIELD_W = 7,
    parameter int SLOT    = 0
) (
    input  logic [FIELD_W-1:0] field_i,
    input  logic               bank_i,
    input  logic [FIELD_W:0]   ptr_i,
    output rfa_pkg::rfa_res_t  res_o
);
    logic field_is_slot;
    logic ptr_is_slot;

    rfa_slot_match #(.W(FIELD_W), .SLOT(SLOT)) u_field_match (
        .offset_i (field_i),
        .hit_o    (field_is_slot)
    );

    rfa_slot_match #(.W(FIELD_W), .SLOT(SLOT)) u_ptr_match (
        .offset_i (ptr_i[FIELD_W-1:0]),
        .hit_o    (ptr_is_slot)
    );

    // Purpose: choose the address source and derive the flags.
    always_comb begin
        res_o.via_ptr  = field_is_slot;
        res_o.addr     = field_is_slot ? ptr_i : {bank_i, field_i};
        res_o.self_ref = field_is_slot & ptr_is_slot;
    end
endmodule

// File: rtl/rfa_out_reg.sv
// Module: rfa_out_reg
// Holds the routed result for one cycle; synchronous active-low reset
// clears the address and both flags.
module rfa_out_reg (
    input  logic              clk,
    input  logic              rst_n,
    input  rfa_pkg::rfa_res_t d_i,
    output rfa_pkg::rfa_res_t q_o
);
    // Purpose: capture the routed result, or clear it during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= d_i;
    end

    // R7: a self reference only ever comes with an indirect access.
    a_r7_self_needs_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        q_o.self_ref |-> q_o.via_ptr);
endmodule

// File: rtl/rfa_addresser.sv
// Module: rfa_addresser (top)
// Register-file address generator. A 7-bit direct field is extended by
// the bank bit; field value 0x00 redirects through the 8-bit pointer.
// Results are registered with one cycle of latency.
module rfa_addresser #(
    parameter int FIELD_W = rfa_pkg::FIELD_W,
    parameter int SLOT    = rfa_pkg::IND_SLOT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] file_field_i,
    input  logic               bank_i,
    input  logic [FIELD_W:0]   ptr_i,
    output logic [FIELD_W:0]   eff_addr_o,
    output logic               via_ptr_o,
    output logic               self_ref_o
);
    localparam logic [FIELD_W-1:0] SLOT_V = FIELD_W'(SLOT);

    rfa_pkg::rfa_res_t routed;
    rfa_pkg::rfa_res_t held;

    rfa_route #(.FIELD_W(FIELD_W), .SLOT(SLOT)) u_route (
        .field_i (file_field_i),
        .bank_i  (bank_i),
        .ptr_i   (ptr_i),
        .res_o   (routed)
    );

    rfa_out_reg u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (routed),
        .q_o   (held)
    );

    // Purpose: expose the registered record on the ports.
    always_comb begin
        eff_addr_o = held.addr;
        via_ptr_o  = held.via_ptr;
        self_ref_o = held.self_ref;
    end

    // R2 / R8: a direct access lands on {bank, field} one cycle later.
    a_r2_direct_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (file_field_i != SLOT_V) |=>
            (eff_addr_o == {$past(bank_i), $past(file_field_i)}) && !via_ptr_o && !self_ref_o);

    // R4 / R5: an indirect access lands on the pointer one cycle later.
    a_r4_indirect_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (file_field_i == SLOT_V) |=> (eff_addr_o == $past(ptr_i)) && via_ptr_o);

    // R6: pointer naming the pseudo-register raises the self flag.
    a_r6_self_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (file_field_i == SLOT_V && ptr_i[FIELD_W-1:0] == SLOT_V) |=> self_ref_o);

    // R6: any other pointer leaves the self flag low.
    a_r6_no_self_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_i[FIELD_W-1:0] != SLOT_V) |=> !self_ref_o);
endmodule

// File: tb/rfa_addresser_bench.sv
`timescale 1ns/1ps
// Bench for rfa_addresser: a behavioural reference predicts every cycle.
module rfa_addresser_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] field = 7'h00;
    logic       bank = 1'b0;
    logic [7:0] ptr = 8'h00;
    logic [7:0] eff_addr;
    logic       via_ptr;
    logic       self_ref;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rfa_addresser u_rfa_addresser (
        .clk          (clk),
        .rst_n        (rst_n),
        .file_field_i (field),
        .bank_i       (bank),
        .ptr_i        (ptr),
        .eff_addr_o   (eff_addr),
        .via_ptr_o    (via_ptr),
        .self_ref_o   (self_ref)
    );

    // Compare the three outputs against the given expected values.
    task automatic compare(input string tag, input int ea, input int ev, input int es);
        checks++;
        if (eff_addr !== 8'(ea) || via_ptr !== 1'(ev) || self_ref !== 1'(es)) begin
            fails++;
            $display("FAIL %s: got addr=%02h via=%0b self=%0b, expected addr=%02h via=%0b self=%0b",
                     tag, eff_addr, via_ptr, self_ref, ea, ev, es);
        end
    endtask

    // Drive one access at a falling edge and check one clock later.
    task automatic step(input int f, input int b, input int p, input string tag);
        int ea;
        int ev;
        int es;
        field = 7'(f);
        bank  = 1'(b);
        ptr   = 8'(p);
        if (f == 0) begin
            ea = p;
            ev = 1;
            es = ((p % 128) == 0) ? 1 : 0;
        end else begin
            ea = b * 128 + f;
            ev = 0;
            es = 0;
        end
        @(negedge clk);
        compare(tag, ea, ev, es);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int lf;
        lf = 32'h1ACE5;
        field = 7'h2A; bank = 1'b1; ptr = 8'h00;
        repeat (3) @(negedge clk);
        compare("R1 reset state", 0, 0, 0);
        rst_n = 1'b1;

        step(7'h05, 0, 8'h99, "R2 direct bank0");
        step(7'h7F, 1, 8'h00, "R3 direct bank1 top");
        step(7'h01, 0, 8'h80, "R3 direct bank0 bottom");
        step(7'h01, 1, 8'h33, "R3 direct bank1 bottom");
        step(7'h00, 0, 8'h3C, "R4 indirect bank0");
        step(7'h00, 1, 8'h3C, "R5 indirect bank ignored");
        step(7'h00, 1, 8'hC7, "R4 indirect high pointer");
        step(7'h00, 0, 8'h00, "R6 self ref ptr 00 bank0");
        step(7'h00, 1, 8'h00, "R6 self ref ptr 00 bank1");
        step(7'h00, 0, 8'h80, "R6 self ref ptr 80 bank0");
        step(7'h00, 1, 8'h80, "R6 self ref ptr 80 bank1");
        step(7'h00, 1, 8'h81, "R6 no self ref ptr 81");
        step(7'h40, 0, 8'h00, "R8 direct ptr 00 ignored");
        step(7'h40, 0, 8'h80, "R8 direct ptr 80 ignored");
        step(7'h12, 1, 8'h80, "R7 direct no self flag");

        for (int i = 0; i < 400; i++) begin
            int f;
            int p;
            lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
            f = (lf[2:0] == 0) ? 0 : lf[9:3];
            p = (lf[12:10] == 0) ? {lf[13], 7'h00} : lf[21:14];
            if (i == 200) begin
                rst_n = 1'b0;
                @(negedge clk);
                compare("R1 mid-run reset", 0, 0, 0);
                rst_n = 1'b1;
            end
            step(f, lf[22], p, (f == 0) ? "R4 R6 random indirect" : "R2 R8 random direct");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule